// File: doc/BRIEF.md
# UART Channel Command and Status Register

This block is the control register set of one channel of a multi-channel UART. A host writes a command byte, mode bytes and transmit bytes through a shared 8-bit write port with a separate strobe for each target, and reads back either the channel status or the selected mode register. Each command write carries four enable and disable bits and a 4-bit command code. The block processes both parts together in one clock.

The block holds the receiver and transmitter enables and two mode registers. The mode registers share one access strobe, and an internal pointer moves from the first register to the second. The block also builds an 8-bit status word. It takes its receive-side state from the occupancy count and error event pins of an external receive FIFO. It returns a flush pulse to that FIFO and a break-change clear pulse to the interrupt logic. It drives level outputs for receive-ready and transmit-ready. Transmit bytes go out only while the transmitter is ready.

Top module: `uart_chan_csr`

## Requirements
- R1: A synchronous active-high reset clears the receiver and transmitter enables, the whole status word, both mode registers and the mode pointer, so the next mode access targets the first mode register.
- R2: In a command write, bit 0 enables the receiver and bit 1 disables it. The disable is applied after the enable, so a write with both bits set leaves the receiver disabled. The result shows on `rxEnable` from the following cycle.
- R3: In a command write, bit 2 sets both status bit 2 (transmitter ready) and status bit 3 (transmitter empty), and bit 3 clears both. Bit 3 is applied after bit 2.
- R4: Command code 2 in bits 7:4 (reset receiver) disables the receiver even when bit 0 of the same write is set. It drives `rxFlush` high during the write cycle, and it forces status bits 0 and 1 to 0 in the following cycle.
- R5: Command code 3 (reset transmitter) clears status bits 2 and 3, even when bit 2 of the same write is set.
- R6: `errEvt[i]` sets status bit 4+i (overrun, parity, framing, received break), and the bit stays set. Command code 4 clears bits 7:4 and no other bit. An event arriving in the same cycle as the clear still sets its bit.
- R7: Command code 5 drives `brkChgClr` high during the write cycle and changes no status bit.
- R8: Command codes 0 and 6 to 15 have no effect beyond the enable and disable bits of the same write. `rxFlush` and `brkChgClr` stay low and status bits 7:4 are kept.
- R9: The mode pointer starts at the first mode register. Any mode write (`modeWr`) or mode read (`modeRd`) moves it to the second register, where it stays until command code 1 returns it to the first. A mode write stores `wrData` in the register the pointer selects before it moves.
- R10: `txPush` is `txWr` gated by status bit 2, in the same cycle, with `txData` equal to `wrData`. A transmit write while status bit 2 is clear is dropped.
- R11: Status bit 0 is 1 one cycle after `rxCount` is nonzero, and status bit 1 is 1 one cycle after `rxCount` equals the FIFO depth. `rxRdyIrq` follows status bit 0 and `txRdyIrq` follows status bit 2.
- R12: `rdData` returns the mode register selected by the pointer while `modeRd` is high, and the status word otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrData | input | 8 | Write data for command, mode and transmit writes |
| cmdWr | input | 1 | Command register write strobe |
| modeWr | input | 1 | Mode register write strobe |
| modeRd | input | 1 | Mode register read strobe, selects mode read data |
| txWr | input | 1 | Transmit data write strobe |
| rxCount | input | 2 | Receive FIFO occupancy |
| errEvt | input | 4 | Error event pulses: overrun, parity, framing, break |
| rdData | output | 8 | Read data: mode register or status word |
| rxEnable | output | 1 | Receiver enable to the FIFO front end |
| txPush | output | 1 | Accepted transmit byte strobe |
| txData | output | 8 | Transmit byte |
| rxFlush | output | 1 | Empty the receive FIFO |
| brkChgClr | output | 1 | Clear the break-change interrupt |
| txRdyIrq | output | 1 | Transmitter ready level to interrupt logic |
| rxRdyIrq | output | 1 | Receiver ready level to interrupt logic |

## Verification
The assertions assume that `cmdWr`, `modeWr` and `modeRd` are never high in the same cycle. They also assume that the FIFO empties `rxCount` at the clock edge that ends a flush and never reports more entries than its depth. The bench drives one strobe per write cycle and models the flush by setting `rxCount` to zero after any reset-receiver write. It keeps `rxCount` within 0 to 3.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  localparam int StRxRdy = 0;
  localparam int StFull  = 1;
  localparam int StTxRdy = 2;
  localparam int StTxEmt = 3;
  localparam int StErrLo = 4;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_PTR_RST = 4'd1,
    CMD_RX_RST  = 4'd2,
    CMD_TX_RST  = 4'd3,
    CMD_ERR_RST = 4'd4,
    CMD_BRK_RST = 4'd5
  } cmdCode_e;

  typedef struct packed {
    logic rxOn;
    logic rxOff;
    logic txOn;
    logic txOff;
    logic ptrRst;
    logic rxRst;
    logic txRst;
    logic errRst;
    logic brkRst;
  } ctlStrobe_t;

endpackage

// File: rtl/uart_chan_ctl.sv
module uart_chan_ctl
  import uart_chan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              cmdWr,
  input  logic [DATA_W-1:0] cmdByte,
  output ctlStrobe_t        strobes
);

  cmdCode_e code;

  always_comb begin
    code    = cmdCode_e'(cmdByte[7:4]);
    strobes = '0;
    if (cmdWr) begin
      strobes.rxOn  = cmdByte[0];
      strobes.rxOff = cmdByte[1];
      strobes.txOn  = cmdByte[2];
      strobes.txOff = cmdByte[3];
      case (code)
        CMD_PTR_RST: strobes.ptrRst = 1'b1;
        CMD_RX_RST:  strobes.rxRst  = 1'b1;
        CMD_TX_RST:  strobes.txRst  = 1'b1;
        CMD_ERR_RST: strobes.errRst = 1'b1;
        CMD_BRK_RST: strobes.brkRst = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/uart_chan_dp.sv
module uart_chan_dp
  import uart_chan_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 3,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int MODE_REGS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              modeWr,
  input  logic              modeRd,
  input  logic              txWr,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [DATA_W-5:0] errEvt,
  output logic [DATA_W-1:0] rdData,
  output logic              rxEnable,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic              rxFlush,
  output logic              brkChgClr,
  output logic              txRdyIrq,
  output logic              rxRdyIrq
);

  localparam int ERR_W = DATA_W - StErrLo;
  localparam int PTR_W = (MODE_REGS > 1) ? $clog2(MODE_REGS) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(MODE_REGS - 1);

  logic              rxEnQ, rxEnN;
  logic              txRdyQ, txRdyN;
  logic [ERR_W-1:0]  errQ;
  logic              rxRdyQ, fullQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [DATA_W-1:0] modeQ [MODE_REGS];
  logic [DATA_W-1:0] statusWord;

  always_comb begin
    rxEnN = rxEnQ;
    if (strobes.rxOn)  rxEnN = 1'b1;
    if (strobes.rxOff) rxEnN = 1'b0;
    if (strobes.rxRst) rxEnN = 1'b0;
    txRdyN = txRdyQ;
    if (strobes.txOn)  txRdyN = 1'b1;
    if (strobes.txOff) txRdyN = 1'b0;
    if (strobes.txRst) txRdyN = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxEnQ  <= 1'b0;
      txRdyQ <= 1'b0;
      errQ   <= '0;
      rxRdyQ <= 1'b0;
      fullQ  <= 1'b0;
      ptrQ   <= '0;
    end else begin
      rxEnQ  <= rxEnN;
      txRdyQ <= txRdyN;
      errQ   <= (strobes.errRst ? '0 : errQ) | errEvt;
      rxRdyQ <= (rxCount != '0) && !strobes.rxRst;
      fullQ  <= (rxCount == FULL_CNT) && !strobes.rxRst;
      if (strobes.ptrRst)
        ptrQ <= '0;
      else if ((modeWr || modeRd) && ptrQ != LAST_PTR)
        ptrQ <= ptrQ + 1'b1;
    end
  end

  for (genvar i = 0; i < MODE_REGS; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst)
        modeQ[i] <= '0;
      else if (modeWr && ptrQ == PTR_W'(i))
        modeQ[i] <= wrData;
    end
  end

  always_comb begin
    statusWord                  = '0;
    statusWord[StRxRdy]         = rxRdyQ;
    statusWord[StFull]          = fullQ;
    statusWord[StTxRdy]         = txRdyQ;
    statusWord[StTxEmt]         = txRdyQ;
    statusWord[DATA_W-1:StErrLo] = errQ;
  end

  assign rdData    = modeRd ? modeQ[ptrQ] : statusWord;
  assign rxEnable  = rxEnQ;
  assign txPush    = txWr && txRdyQ;
  assign txData    = wrData;
  assign rxFlush   = strobes.rxRst;
  assign brkChgClr = strobes.brkRst;
  assign txRdyIrq  = statusWord[StTxRdy];
  assign rxRdyIrq  = statusWord[StRxRdy];

endmodule

// File: rtl/uart_chan_csr.sv
module uart_chan_csr
  import uart_chan_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 3,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdWr,
  input  logic              modeWr,
  input  logic              modeRd,
  input  logic              txWr,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [3:0]        errEvt,
  output logic [DATA_W-1:0] rdData,
  output logic              rxEnable,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic              rxFlush,
  output logic              brkChgClr,
  output logic              txRdyIrq,
  output logic              rxRdyIrq
);

  ctlStrobe_t strobes;

  uart_chan_ctl #(.DATA_W(DATA_W)) u_ctl (
    .cmdWr  (cmdWr),
    .cmdByte(wrData),
    .strobes(strobes)
  );

  uart_chan_dp #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .CNT_W     (CNT_W),
    .MODE_REGS (2)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrData   (wrData),
    .modeWr   (modeWr),
    .modeRd   (modeRd),
    .txWr     (txWr),
    .rxCount  (rxCount),
    .errEvt   (errEvt),
    .rdData   (rdData),
    .rxEnable (rxEnable),
    .txPush   (txPush),
    .txData   (txData),
    .rxFlush  (rxFlush),
    .brkChgClr(brkChgClr),
    .txRdyIrq (txRdyIrq),
    .rxRdyIrq (rxRdyIrq)
  );

endmodule

// File: rtl/uart_chan_csr_chk.sv
module uart_chan_csr_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] wrData,
  input logic              cmdWr,
  input logic              txWr,
  input logic [CNT_W-1:0]  rxCount,
  input logic              rxEnable,
  input logic              txPush,
  input logic              rxFlush,
  input logic              txRdyIrq,
  input logic              rxRdyIrq
);

  assert_rx_on_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && wrData[0] && !wrData[1] && wrData[7:4] != 4'd2) |=> rxEnable);

  assert_rx_off_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && wrData[1]) |=> !rxEnable);

  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cmdWr |=> $stable(rxEnable));

  assert_tx_on_R3: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && wrData[2] && !wrData[3] && wrData[7:4] != 4'd3) |=> txRdyIrq);

  assert_tx_off_R5: assert property (@(posedge clk) disable iff (rst)
    (cmdWr && (wrData[3] || wrData[7:4] == 4'd3)) |=> !txRdyIrq);

  assert_rx_reset_R4: assert property (@(posedge clk) disable iff (rst)
    rxFlush |=> (!rxEnable && !rxRdyIrq));

  assert_tx_gate_R10: assert property (@(posedge clk) disable iff (rst)
    txPush |-> (txWr && txRdyIrq));

  assert_rxrdy_R11: assert property (@(posedge clk) disable iff (rst)
    (!cmdWr && rxCount != '0) |=> rxRdyIrq);

endmodule

bind uart_chan_csr uart_chan_csr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wrData  (wrData),
  .cmdWr   (cmdWr),
  .txWr    (txWr),
  .rxCount (rxCount),
  .rxEnable(rxEnable),
  .txPush  (txPush),
  .rxFlush (rxFlush),
  .txRdyIrq(txRdyIrq),
  .rxRdyIrq(rxRdyIrq)
);

// File: tb/tb_uart_chan_csr.sv
module tb_uart_chan_csr;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] wrData;
  logic       cmdWr, modeWr, modeRd, txWr;
  logic [1:0] rxCount;
  logic [3:0] errEvt;
  logic [7:0] rdData, txData;
  logic       rxEnable, txPush, rxFlush, brkChgClr, txRdyIrq, rxRdyIrq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  uart_chan_csr dut (
    .clk(clk), .rst(rst), .wrData(wrData), .cmdWr(cmdWr), .modeWr(modeWr),
    .modeRd(modeRd), .txWr(txWr), .rxCount(rxCount), .errEvt(errEvt),
    .rdData(rdData), .rxEnable(rxEnable), .txPush(txPush), .txData(txData),
    .rxFlush(rxFlush), .brkChgClr(brkChgClr), .txRdyIrq(txRdyIrq),
    .rxRdyIrq(rxRdyIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrData = '0; cmdWr = 0; modeWr = 0; modeRd = 0; txWr = 0; errEvt = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] v);
    idle(); cmdWr = 1; wrData = v;
    step();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); rxCount = '0; rst = 1;
    step(); step();
    rst = 0;
    #1;
    // R1 reset state
    check("R1 status", rdData, 8'h00);
    check("R1 rxEnable", rxEnable, 0);
    modeRd = 1; #1;
    check("R1 mode reads zero", rdData, 8'h00);
    modeRd = 0;
    step();

    // R9 mode pointer: first write targets MR1, then MR2 sticks
    idle(); modeWr = 1; wrData = 8'h11; step();
    modeWr = 1; wrData = 8'h22; step();
    modeWr = 1; wrData = 8'h33; step();
    idle();
    cmd(8'h10);
    modeRd = 1; #1;
    check("R9 MR1 after pointer reset", rdData, 8'h11);
    step(); #1;
    check("R9 MR2 after read advance", rdData, 8'h33);
    step(); #1;
    check("R9 pointer stays on MR2", rdData, 8'h33);
    modeRd = 0; #1;
    check("R12 status when no mode read", rdData, 8'h00);
    step();

    // R10 transmit gating
    idle(); txWr = 1; wrData = 8'hA5; #1;
    check("R10 drop when not ready", txPush, 0);
    step(); idle();
    cmd(8'h04);
    txWr = 1; wrData = 8'h5A; #1;
    check("R10 push when ready", txPush, 1);
    check("R10 data", txData, 8'h5A);
    step(); idle();

    // R11 occupancy flags
    rxCount = 2'd3; step(); #1;
    check("R11 full and ready", rdData[1:0], 2'b11);
    check("R11 rxRdyIrq", rxRdyIrq, 1);
    check("R11 txRdyIrq", txRdyIrq, 1);
    rxCount = 2'd2; step(); #1;
    check("R11 not full", rdData[1:0], 2'b01);
    rxCount = 2'd0; step(); #1;
    check("R11 empty", rdData[1:0], 2'b00);

    // R6 event sets while clear in same cycle
    idle(); errEvt = 4'b0101; step(); idle(); #1;
    check("R6 sticky errors", rdData[7:4], 4'b0101);
    idle(); cmdWr = 1; wrData = 8'h40; errEvt = 4'b1000; step(); idle(); #1;
    check("R6 event beats clear", rdData[7:4], 4'b1000);

    // R2..R8 sweep over every command byte from two start states
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 256; v++) begin
        logic [3:0] code;
        logic       expRx, expTx, expRdy;
        logic [3:0] expErr;
        code = v[7:4];
        cmd(s ? 8'h05 : 8'h0A);
        errEvt = 4'hF; rxCount = 2'd1; step(); idle();
        idle(); cmdWr = 1; wrData = v[7:0]; #1;
        check((code == 2) ? "R4 flush" : "R8 no flush", rxFlush, code == 2);
        check((code == 5) ? "R7 break clear" : "R8 no break clear", brkChgClr, code == 5);
        step(); idle(); #1;
        expRx = s[0];
        if (v[0]) expRx = 1;
        if (v[1]) expRx = 0;
        if (code == 2) expRx = 0;
        expTx = s[0];
        if (v[2]) expTx = 1;
        if (v[3]) expTx = 0;
        if (code == 3) expTx = 0;
        expErr = (code == 4) ? 4'h0 : 4'hF;
        expRdy = (code != 2);
        check((code == 2) ? "R4 rxEnable" : "R2 rxEnable", rxEnable, expRx);
        check((code == 3) ? "R5 status" : (code == 4) ? "R6 status" : "R3 status",
              rdData, {expErr, expTx, expTx, 1'b0, expRdy});
        if (code == 2) rxCount = 2'd0;
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule